// File: doc/BRIEF.md
# Dual-Resolution DDA PWM Generator

This block produces a pulse-width-modulated control waveform, suitable for driving a tuning or motor voltage through a simple low-pass filter, from a 14-bit setpoint. The setpoint is split into a coarse and a fine field. The coarse field sets how long the output is held low inside a short cycle of fixed length. Because the cycle is short, the ripple frequency stays high and the filter can stay small.

The fine field does not lengthen the counter. Once per cycle an error accumulator, working like a digital differential analyser, decides whether the following cycle gets one extra time quantum of high output. Over many cycles the extensions are spread as evenly as the fine value allows. The result has the full 14-bit resolution with no multiply and no divide. A sync output marks the cycles that carry an extension, so an oscilloscope can trigger on them.

Time is counted in ticks of an external microsecond strobe. A new setpoint is staged and takes effect only at a cycle boundary. A stop request halts the waveform at the next boundary, and loading a setpoint while stopped starts a fresh cycle.

Top module: `dda_pwm_gen`

## Requirements
- R1: After reset the coarse field is 2^(COARSE_W-1)-1 (63 by default), the fine field is 0, the accumulator is 0 and no extension is pending. The generator is running, at the first tick position of a cycle, with `pwm_out` low and `ext_sync` low.
- R2: Each cycle begins with the extension (QUANTUM ticks of high output if the cycle is extended, none otherwise). The output is then low for exactly coarse*QUANTUM+1 ticks, where the coarse field is `sp_value[13:7]` by default.
- R3: A cycle lasts CYCLE ticks (512 by default), or CYCLE+QUANTUM ticks when extended. The output is high for every tick of the cycle outside the low window.
- R4: At every cycle end the accumulator gains (2^FINE_W-1) minus the fine field that applied to that cycle. If the sum reaches 2^(FINE_W-1), 2^FINE_W-1 is subtracted and the next cycle is extended. Otherwise the next cycle is not extended. The accumulator therefore stays within [2^(FINE_W-1)-(2^FINE_W-1), 2^(FINE_W-1)-1].
- R5: With the fine field F (`sp_value[6:0]` by default) held for 2^FINE_W-1 consecutive cycle decisions, exactly 2^FINE_W-1-F cycles are extended. The spacings between consecutive extensions differ by at most one cycle.
- R6: `ext_sync` is high for the whole of every extended cycle and low for the whole of every other cycle.
- R7: A pulse on `sp_load` while running stages `sp_value`. It replaces the coarse and fine fields only at the next cycle end, and the cycle in progress keeps its old shape. If several loads come before one cycle end, the last one wins.
- R8: A pulse on `stop_req` while running takes effect at the next cycle end. It discards any staged setpoint, and from then on `pwm_out` and `ext_sync` stay low whatever `us_tick` does.
- R9: A pulse on `sp_load` while stopped applies `sp_value` on the next clock. It starts a cycle at its first tick position, with the accumulator cleared and no extension.
- R10: Clocks in which `us_tick` is low leave `pwm_out` and `ext_sync` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-clock strobe per microsecond time step |
| sp_load | input | 1 | Load strobe for `sp_value` |
| sp_value | input | COARSE_W+FINE_W | Setpoint: coarse field in the upper bits, fine field in the lower bits |
| stop_req | input | 1 | Request to halt at the next cycle end |
| pwm_out | output | 1 | Modulated output, high = on |
| ext_sync | output | 1 | High during cycles that carry the extra quantum |

## Verification
The bench sweeps every coarse value and every fine value of a reduced configuration. It follows each tick of each cycle, so an off-by-one in the low window, a cycle one tick short or long, or an extension placed after the low phase instead of before it shows up at once. For each fine value it counts the extensions across a full accumulator period and measures the gaps between them. A wrong threshold or a sign slip in the accumulator gives the wrong count or bunched extensions. Staged loads and stops are issued in mid-cycle to catch a design that switches the setpoint or halts before the boundary, keeps a staged value after a stop, or fails to clear the accumulator when it restarts.

// File: rtl/dda_pwm_pkg.sv
package dda_pwm_pkg;

  // Low-phase length in ticks for a coarse value.
  function automatic int off_ticks(input int coarse, input int quantum);
    return coarse * quantum + 1;
  endfunction

  // Accumulator value before the threshold decision.
  function automatic int acc_step(input int acc, input int fine, input int norm);
    return acc + (norm - fine);
  endfunction

  // Threshold decision: true when the cycle that follows is extended.
  function automatic bit crosses(input int value, input int half);
    return value >= half;
  endfunction

endpackage

// File: rtl/dda_sp_holder.sv
module dda_sp_holder #(
  parameter int COARSE_W = 7,
  parameter int FINE_W   = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sp_load,
  input  logic [COARSE_W+FINE_W-1:0] sp_value,
  input  logic                       stop_req,
  input  logic                       cycle_end,
  output logic [COARSE_W-1:0]        coarse,
  output logic [FINE_W-1:0]          fine,
  output logic                       running,
  output logic                       restart
);
  localparam int SPW = COARSE_W + FINE_W;
  localparam logic [COARSE_W-1:0] RST_COARSE = {1'b0, {(COARSE_W-1){1'b1}}};

  logic [SPW-1:0] staged;
  logic           staged_vld;
  logic           stop_pend;

  // A load while halted restarts the generator on the next clock.
  assign restart = !running && sp_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarse     <= RST_COARSE;
      fine       <= '0;
      running    <= 1'b1;
      staged     <= '0;
      staged_vld <= 1'b0;
      stop_pend  <= 1'b0;
    end else if (!running) begin
      if (sp_load) begin
        coarse  <= sp_value[SPW-1:FINE_W];
        fine    <= sp_value[FINE_W-1:0];
        running <= 1'b1;
      end
    end else if (cycle_end) begin
      if (stop_pend || stop_req) begin
        running    <= 1'b0;
        staged_vld <= 1'b0;
        stop_pend  <= 1'b0;
      end else begin
        if (sp_load) begin
          coarse <= sp_value[SPW-1:FINE_W];
          fine   <= sp_value[FINE_W-1:0];
        end else if (staged_vld) begin
          coarse <= staged[SPW-1:FINE_W];
          fine   <= staged[FINE_W-1:0];
        end
        staged_vld <= 1'b0;
      end
    end else begin
      if (sp_load) begin
        staged     <= sp_value;
        staged_vld <= 1'b1;
      end
      if (stop_req) stop_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/dda_accum.sv
module dda_accum
  import dda_pwm_pkg::*;
#(
  parameter int FINE_W = 7,
  parameter int ACC_W  = FINE_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cycle_end,
  input  logic                    restart,
  input  logic [FINE_W-1:0]       fine,
  output logic signed [ACC_W-1:0] acc,
  output logic                    ext_on,
  output logic                    will_extend
);
  localparam int NORM = (1 << FINE_W) - 1;
  localparam int HALF = 1 << (FINE_W - 1);

  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W-1:0] acc_nxt;

  always_comb begin
    sum         = ACC_W'(acc_step(int'(acc), int'(fine), NORM));
    will_extend = crosses(int'(sum), HALF);
    acc_nxt     = will_extend ? ACC_W'(int'(sum) - NORM) : sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      acc    <= '0;
      ext_on <= 1'b0;
    end else if (cycle_end) begin
      acc    <= acc_nxt;
      ext_on <= will_extend;
    end
  end
endmodule

// File: rtl/dda_cycle_timer.sv
module dda_cycle_timer
  import dda_pwm_pkg::*;
#(
  parameter int COARSE_W = 7,
  parameter int QUANTUM  = 2,
  parameter int CYCLE    = 512,
  parameter int PW       = $clog2(CYCLE + QUANTUM)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                us_tick,
  input  logic                running,
  input  logic                restart,
  input  logic                ext_on,
  input  logic [COARSE_W-1:0] coarse,
  output logic [PW-1:0]       pos,
  output logic                cycle_end,
  output logic                pwm_out,
  output logic                ext_sync
);
  localparam logic [PW-1:0] LAST_PLAIN = PW'(CYCLE - 1);
  localparam logic [PW-1:0] LAST_EXT   = PW'(CYCLE + QUANTUM - 1);

  int   ext_len;
  int   off_end;
  logic in_off;

  assign cycle_end = running && us_tick && (pos == (ext_on ? LAST_EXT : LAST_PLAIN));

  always_comb begin
    ext_len = ext_on ? QUANTUM : 0;
    off_end = ext_len + off_ticks(int'(coarse), QUANTUM);
    in_off  = (int'(pos) >= ext_len) && (int'(pos) < off_end);
  end

  assign pwm_out  = running && !in_off;
  assign ext_sync = running && ext_on;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !running || cycle_end) pos <= '0;
    else if (us_tick) pos <= pos + PW'(1);
  end
endmodule

// File: rtl/dda_pwm_gen.sv
module dda_pwm_gen #(
  parameter int COARSE_W = 7,
  parameter int FINE_W   = 7,
  parameter int QUANTUM  = 2,
  parameter int CYCLE    = 512
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       us_tick,
  input  logic                       sp_load,
  input  logic [COARSE_W+FINE_W-1:0] sp_value,
  input  logic                       stop_req,
  output logic                       pwm_out,
  output logic                       ext_sync
);
  localparam int ACC_W = FINE_W + 2;
  localparam int PW    = $clog2(CYCLE + QUANTUM);

  logic [COARSE_W-1:0]     coarse;
  logic [FINE_W-1:0]       fine;
  logic                    running;
  logic                    restart;
  logic                    cycle_end;
  logic                    ext_on;
  logic                    will_extend;
  logic signed [ACC_W-1:0] acc;
  logic [PW-1:0]           pos;

  dda_sp_holder #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_sp (
    .clk(clk), .rst_n(rst_n), .sp_load(sp_load), .sp_value(sp_value),
    .stop_req(stop_req), .cycle_end(cycle_end), .coarse(coarse), .fine(fine),
    .running(running), .restart(restart)
  );

  dda_accum #(.FINE_W(FINE_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end), .restart(restart),
    .fine(fine), .acc(acc), .ext_on(ext_on), .will_extend(will_extend)
  );

  dda_cycle_timer #(.COARSE_W(COARSE_W), .QUANTUM(QUANTUM), .CYCLE(CYCLE), .PW(PW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .running(running),
    .restart(restart), .ext_on(ext_on), .coarse(coarse), .pos(pos),
    .cycle_end(cycle_end), .pwm_out(pwm_out), .ext_sync(ext_sync)
  );
endmodule

// File: rtl/dda_pwm_chk.sv
module dda_pwm_chk #(
  parameter int FINE_W  = 7,
  parameter int ACC_W   = FINE_W + 2,
  parameter int PW      = 10,
  parameter int QUANTUM = 2,
  parameter int CYCLE   = 512
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    us_tick,
  input logic                    running,
  input logic                    cycle_end,
  input logic                    will_extend,
  input logic                    ext_on,
  input logic                    pwm_out,
  input logic                    ext_sync,
  input logic signed [ACC_W-1:0] acc,
  input logic [PW-1:0]           pos
);
  localparam int NORM = (1 << FINE_W) - 1;
  localparam int HALF = 1 << (FINE_W - 1);

  // R4
  acc_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(acc) >= HALF - NORM) && (int'(acc) < HALF));

  // R4
  ext_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && running) |=> (ext_on == $past(will_extend)));

  // R3
  pos_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos) < CYCLE + (ext_on ? QUANTUM : 0));

  // R2
  ext_head_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pos == '0 && ext_sync) |-> pwm_out);

  // R6
  sync_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !cycle_end) |=> $stable(ext_sync));

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!pwm_out && !ext_sync));

  // R10
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !us_tick) |=> ($stable(pwm_out) && $stable(ext_sync)));
endmodule

bind dda_pwm_gen dda_pwm_chk #(
  .FINE_W(FINE_W), .ACC_W(ACC_W), .PW(PW), .QUANTUM(QUANTUM), .CYCLE(CYCLE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .running(running),
  .cycle_end(cycle_end), .will_extend(will_extend), .ext_on(ext_on),
  .pwm_out(pwm_out), .ext_sync(ext_sync), .acc(acc), .pos(pos)
);

// File: tb/dda_pwm_gen_test.sv
module dda_pwm_gen_test;
  localparam int CW = 3;
  localparam int FW = 4;
  localparam int Q = 2;
  localparam int CYC = 32;
  localparam int NORM = (1 << FW) - 1;
  localparam int HALF = 1 << (FW - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0;
  logic sp_load = 1'b0;
  logic stop_req = 1'b0;
  logic [CW+FW-1:0] sp_value = '0;
  logic pwm_out;
  logic ext_sync;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // expected state derived from the requirements
  int m_up, m_lo, m_acc, m_ext, m_run;
  int p_vld, p_up, p_lo, p_stop;

  always #4 clk = ~clk;

  dda_pwm_gen #(.COARSE_W(CW), .FINE_W(FW), .QUANTUM(Q), .CYCLE(CYC)) uut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .sp_load(sp_load),
    .sp_value(sp_value), .stop_req(stop_req), .pwm_out(pwm_out), .ext_sync(ext_sync)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    us_tick = 1'b1;
    @(negedge clk);
    us_tick = 1'b0;
  endtask

  task automatic load(input int up, input int lo);
    sp_value = {CW'(up), FW'(lo)};
    sp_load = 1'b1;
    @(negedge clk);
    sp_load = 1'b0;
    if (m_run == 0) begin
      m_up = up; m_lo = lo; m_run = 1; m_acc = 0; m_ext = 0;
    end else begin
      p_vld = 1; p_up = up; p_lo = lo;
    end
  endtask

  task automatic req_stop();
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    if (m_run != 0) p_stop = 1;
  endtask

  // Walks one cycle tick by tick; gap_at >= 0 inserts idle clocks there.
  task automatic run_cycle(input string req, input int gap_at, output int saw_sync);
    int len, ext_t, off_n, bad, act, expv, s;
    ext_t = (m_ext != 0) ? Q : 0;
    len = CYC + ext_t;
    off_n = m_up * Q + 1;
    bad = 0; act = 0; expv = 0;
    saw_sync = int'(ext_sync);
    for (int p = 0; p < len; p++) begin
      int e_pwm;
      e_pwm = (p >= ext_t && p < ext_t + off_n) ? 0 : 1;
      if (pwm_out !== e_pwm[0] || ext_sync !== m_ext[0]) begin
        if (bad == 0) begin
          act = p * 10 + int'(pwm_out) * 2 + int'(ext_sync);
          expv = p * 10 + e_pwm * 2 + m_ext;
        end
        bad++;
      end
      if (p == gap_at) begin
        repeat (3) @(negedge clk);
        // R10: idle clocks must not move the outputs
        chk(pwm_out === e_pwm[0] && ext_sync === m_ext[0], "R10 idle hold",
            int'(pwm_out) * 2 + int'(ext_sync), e_pwm * 2 + m_ext);
      end
      do_tick();
    end
    chk(bad == 0, {req, " R2 R3 R6 cycle shape (pos*10+pwm*2+sync)"}, act, expv);
    s = m_acc + NORM - m_lo;
    if (s >= HALF) begin m_acc = s - NORM; m_ext = 1; end
    else begin m_acc = s; m_ext = 0; end
    if (p_stop != 0) begin
      m_run = 0; p_stop = 0; p_vld = 0;
    end else if (p_vld != 0) begin
      m_up = p_up; m_lo = p_lo; p_vld = 0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ss;
    m_up = (1 << (CW - 1)) - 1; m_lo = 0; m_acc = 0; m_ext = 0; m_run = 1;
    p_vld = 0; p_up = 0; p_lo = 0; p_stop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state visible at the ports
    chk(pwm_out === 1'b0, "R1 pwm after reset", int'(pwm_out), 0);
    chk(ext_sync === 1'b0, "R1 sync after reset", int'(ext_sync), 0);
    run_cycle("R1", -1, ss);
    // R4: fine=0 extends every following cycle
    run_cycle("R4", 4, ss);
    chk(ss == 1, "R4 extension after fine=0", ss, 1);
    run_cycle("R4", -1, ss);

    // coarse sweep
    for (int u = 0; u < (1 << CW); u++) begin
      load(u, 7);
      run_cycle("R2", -1, ss);
      run_cycle("R2", (u == 3) ? 9 : -1, ss);
    end

    // fine sweep: extension count and spacing (R5)
    for (int l = 0; l < (1 << FW); l++) begin
      int cnt, last, gmin, gmax;
      load((l * 3) % (1 << CW), l);
      run_cycle("R7", -1, ss);
      run_cycle("R4", -1, ss);
      cnt = 0; last = -1; gmin = 1000; gmax = 0;
      for (int c = 0; c < NORM; c++) begin
        run_cycle("R5", -1, ss);
        if (ss != 0) begin
          cnt++;
          if (last >= 0) begin
            if (c - last < gmin) gmin = c - last;
            if (c - last > gmax) gmax = c - last;
          end
          last = c;
        end
      end
      chk(cnt == NORM - l, "R5 extension count", cnt, NORM - l);
      chk(cnt < 2 || gmax - gmin <= 1, "R5 spacing spread", gmax - gmin, 1);
    end

    // R7: two staged loads, last wins, current cycle unchanged
    load(2, 1);
    load(6, 9);
    run_cycle("R7", 6, ss);
    run_cycle("R7", -1, ss);
    chk(m_up == 6, "R7 last load wins (model)", m_up, 6);
    run_cycle("R7", -1, ss);

    // R8: staged load plus stop: stop wins at the boundary
    load(4, 4);
    req_stop();
    run_cycle("R8", -1, ss);
    for (int k = 0; k < 6; k++) begin
      chk(pwm_out === 1'b0 && ext_sync === 1'b0, "R8 halted outputs",
          int'(pwm_out) * 2 + int'(ext_sync), 0);
      do_tick();
    end

    // R9: load while halted restarts with cleared accumulator
    load(5, 2);
    run_cycle("R9", -1, ss);
    chk(ss == 0, "R9 no extension on restart", ss, 0);
    run_cycle("R9", -1, ss);
    run_cycle("R9", -1, ss);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule